// File: doc/BRIEF.md
# Multichannel Wait-Hold Pulse-Width Generator

This block generates seven independent pulse-width-modulated signals from one source clock. Each channel has two counts. The high count sets how many source-clock cycles the output spends high. The low count sets how many cycles follow at low level. The pattern then repeats. A channel produces a waveform only when three enables are all set: a counter-reset enable, a counter-advance enable and an output gate. A per-channel bypass bit routes the source clock itself to the pin instead of the divided waveform. Six channels drive pins that leave the chip, and the seventh drives an internal net.

Software programs the block through a plain word-addressed register port. Writes take effect in one cycle, and reads return data combinationally from the presented address. The block clock `clk` is also the source clock that the counters measure, so every count is in `clk` cycles. A count field of zero stands for the largest count, 2^CNT_W. A new count written while a channel runs is held back until the current period ends, so no phase is ever cut short.

Top module: `pwm_wh_ctrl`

## Requirements
- R1: There are seven channels. Channels 0 to 5 appear on `pwm_ext[5:0]`, bit for bit, and channel 6 appears only on `pwm_int`.
- R2: While `rst_n` is low at a clock edge, every register returns to 0 and every output goes low.
- R3: In divider mode, a running channel is high for W cycles and then low for H cycles, repeating. W is its high-count field and H its low-count field. The first high cycle is the cycle right after the edge that sets the last missing enable.
- R4: A high-count or low-count field holding 0 means 65536 cycles.
- R5: A channel's output is low whenever its output-gate bit, its counter-reset enable or its counter-advance enable is clear.
- R6: While a channel's counter-reset enable (bit n at 0x08) is clear, its counter is held at the start of the high phase. When the bit is set again, the waveform restarts with a full high phase.
- R7: While a channel's counter-advance enable (bit n at 0x0C) is clear, its counter keeps its position. Once the bit is set again, the waveform resumes from that position.
- R8: With bypass bit 21+n of the register at 0x00 set and all three enables on, channel n's output equals the source clock level.
- R9: A high or low count written while the channel runs is first used in the period that starts after the current period ends.
- R10: Register map, each register reading back its writable bits with all other bits reading 0:
  - 0x00 holds seven 3-bit source-select fields in bits [20:0] (channel n at [3n+2:3n]) and bypass bits in [27:21].
  - 0x04 holds output gates in bits [6:0] and transition-mode bits in [13:7].
  - 0x08 holds the counter-reset enables in bits [6:0].
  - 0x0C holds the counter-advance enables in bits [6:0].
  - 0x10+8n holds channel n's 16-bit high count.
  - 0x14+8n holds channel n's 16-bit low count.
- R11: Addresses with bits [1:0] not zero, or at 0x48 and above, read as 0, and writes to them change no register.
- R12: The source-select fields and transition-mode bits are stored but do not change any waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source clock that is counted and bypassed |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_ext | output | 6 | Outputs of channels 0 to 5 |
| pwm_int | output | 1 | Output of channel 6 |

## Verification
The bench builds the block with its default parameters: seven channels, 16-bit count fields and an 8-bit address. With seven channels the map reaches up to 0x44, so the highest register, the first unmapped word and the separate internal output all come within reach. With 16-bit fields, the zero-means-65536 case takes only about 65 thousand cycles, so the bench can run one full long phase and see it end exactly on time. Count updates in mid-run, pausing and resetting a running counter, bypass, and stored fields that must not affect the waveform are each driven on a single channel while the others stay idle.

// File: rtl/pwm_wh_pkg.sv
// Package pwm_wh_pkg
// Register offsets and shared types for the wait-hold PWM controller.
// Assumes a byte-addressed, word-aligned register port.
package pwm_wh_pkg;

    localparam int OFS_SEL     = 'h00;  // source select + bypass
    localparam int OFS_GATE    = 'h04;  // output gates + transition mode
    localparam int OFS_RUN     = 'h08;  // counter-reset enables
    localparam int OFS_ADV     = 'h0C;  // counter-advance enables
    localparam int OFS_CH_BASE = 'h10;  // first channel count register
    localparam int CH_STRIDE   = 8;     // bytes between channel pairs
    localparam int LOW_OFS     = 4;     // low count after high count

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    // Byte offset of channel n's high-count register.
    function automatic int high_ofs(input int n);
        return OFS_CH_BASE + n * CH_STRIDE;
    endfunction

    // Byte offset of channel n's low-count register.
    function automatic int low_ofs(input int n);
        return OFS_CH_BASE + n * CH_STRIDE + LOW_OFS;
    endfunction

endpackage

// File: rtl/pwm_wh_regs.sv
// Module pwm_wh_regs
// Register file of the wait-hold PWM controller: decodes single-cycle
// writes, holds every control field and returns read data combinationally.
// Assumes DW covers the select fields plus the bypass bits (NCH*(SEL_W+1)).
// Unmapped and misaligned addresses read as zero and are never written.
module pwm_wh_regs
    import pwm_wh_pkg::*;
#(
    parameter int NCH   = 7,
    parameter int CW    = 16,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NCH-1:0]    byp_q,
    output logic [NCH-1:0]    gate_q,
    output logic [NCH-1:0]    run_q,
    output logic [NCH-1:0]    adv_q,
    output logic [NCH*CW-1:0] high_flat,
    output logic [NCH*CW-1:0] low_flat
);

    localparam int SELF_W  = NCH * SEL_W;   // width of all select fields
    localparam int BYP_LSB = SELF_W;        // bypass bits follow selects
    localparam int TM_LSB  = NCH;           // transition bits follow gates

    localparam logic [AW-1:0] A_SEL  = AW'(OFS_SEL);
    localparam logic [AW-1:0] A_GATE = AW'(OFS_GATE);
    localparam logic [AW-1:0] A_RUN  = AW'(OFS_RUN);
    localparam logic [AW-1:0] A_ADV  = AW'(OFS_ADV);

    logic [SELF_W-1:0] sel_q;
    logic [NCH-1:0]    tm_q;
    logic [CW-1:0]     high_r [NCH];
    logic [CW-1:0]     low_r  [NCH];

    // Shared control registers: written on an exact address match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            byp_q  <= '0;
            gate_q <= '0;
            tm_q   <= '0;
            run_q  <= '0;
            adv_q  <= '0;
        end else if (wen) begin
            if (addr == A_SEL) begin
                sel_q <= wdata[SELF_W-1:0];
                byp_q <= wdata[BYP_LSB +: NCH];
            end
            if (addr == A_GATE) begin
                gate_q <= wdata[NCH-1:0];
                tm_q   <= wdata[TM_LSB +: NCH];
            end
            if (addr == A_RUN) run_q <= wdata[NCH-1:0];
            if (addr == A_ADV) adv_q <= wdata[NCH-1:0];
        end
    end

    // Per-channel count registers, one pair per channel.
    for (genvar n = 0; n < NCH; n++) begin : g_cnt_reg
        localparam logic [AW-1:0] A_HI = AW'(high_ofs(n));
        localparam logic [AW-1:0] A_LO = AW'(low_ofs(n));

        // Store this channel's high and low counts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                high_r[n] <= '0;
                low_r[n]  <= '0;
            end else if (wen) begin
                if (addr == A_HI) high_r[n] <= wdata[CW-1:0];
                if (addr == A_LO) low_r[n]  <= wdata[CW-1:0];
            end
        end

        assign high_flat[n*CW +: CW] = high_r[n];
        assign low_flat[n*CW +: CW]  = low_r[n];
    end

    // Read mux: zero unless the address names a register.
    always_comb begin
        rdata = '0;
        if (addr == A_SEL) begin
            rdata[SELF_W-1:0]     = sel_q;
            rdata[BYP_LSB +: NCH] = byp_q;
        end
        if (addr == A_GATE) begin
            rdata[NCH-1:0]       = gate_q;
            rdata[TM_LSB +: NCH] = tm_q;
        end
        if (addr == A_RUN) rdata[NCH-1:0] = run_q;
        if (addr == A_ADV) rdata[NCH-1:0] = adv_q;
        for (int n = 0; n < NCH; n++) begin
            if (addr == AW'(high_ofs(n))) rdata[CW-1:0] = high_r[n];
            if (addr == AW'(low_ofs(n)))  rdata[CW-1:0] = low_r[n];
        end
    end

endmodule

// File: rtl/pwm_wh_chan.sv
// Module pwm_wh_chan
// One wait-hold channel: a phase flag and a cycle counter that run a
// high phase of W cycles and a low phase of H cycles, with the output gated
// by three enables and an optional pass-through of the source clock.
// Assumes src_clk is the clock this module runs on. A count of zero means
// 2^CW because the limit is formed as count-1 modulo 2^CW.
module pwm_wh_chan
    import pwm_wh_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_clk,
    input  logic          run_en,
    input  logic          adv_en,
    input  logic          gate_en,
    input  logic          bypass,
    input  logic [CW-1:0] high_cnt,
    input  logic [CW-1:0] low_cnt,
    output logic          pwm
);

    localparam logic [CW-1:0] ONE = CW'(1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] high_sh;
    logic [CW-1:0] low_sh;
    logic [CW-1:0] lim;
    logic          at_end;

    // Last count value of the current phase.
    always_comb begin
        lim    = (phase_q == PH_HIGH) ? (high_sh - ONE) : (low_sh - ONE);
        at_end = (cnt_q == lim);
    end

    // Counter: held at start while stopped, frozen while not advancing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            high_sh <= '0;
            low_sh  <= '0;
        end else if (!run_en) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            high_sh <= high_cnt;
            low_sh  <= low_cnt;
        end else if (adv_en) begin
            if (!at_end) begin
                cnt_q <= cnt_q + ONE;
            end else begin
                cnt_q <= '0;
                if (phase_q == PH_HIGH) begin
                    phase_q <= PH_LOW;
                end else begin
                    phase_q <= PH_HIGH;
                    high_sh <= high_cnt;
                    low_sh  <= low_cnt;
                end
            end
        end
    end

    // Output gating: all three enables, then bypass or divided level.
    always_comb begin
        if (run_en && adv_en && gate_en)
            pwm = bypass ? src_clk : (phase_q == PH_HIGH);
        else
            pwm = 1'b0;
    end

endmodule

// File: rtl/pwm_wh_ctrl.sv
// Module pwm_wh_ctrl
// Top of the seven-channel wait-hold PWM controller: one register file and
// NCH channel engines. The last channel feeds an internal net and all
// others feed external pins. Assumes clk is also the source clock.
module pwm_wh_ctrl
    import pwm_wh_pkg::*;
#(
    parameter int NCH   = 7,
    parameter int CW    = 16,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int SEL_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wen,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-2:0] pwm_ext,
    output logic           pwm_int
);

    localparam int NEXT = NCH - 1;  // number of external channels

    logic [NCH-1:0]    byp_q;
    logic [NCH-1:0]    gate_q;
    logic [NCH-1:0]    run_q;
    logic [NCH-1:0]    adv_q;
    logic [NCH*CW-1:0] high_flat;
    logic [NCH*CW-1:0] low_flat;
    logic [NCH-1:0]    out_all;

    pwm_wh_regs #(
        .NCH(NCH), .CW(CW), .AW(AW), .DW(DW), .SEL_W(SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (bus_wen),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .byp_q    (byp_q),
        .gate_q   (gate_q),
        .run_q    (run_q),
        .adv_q    (adv_q),
        .high_flat(high_flat),
        .low_flat (low_flat)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        pwm_wh_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_clk (clk),
            .run_en  (run_q[n]),
            .adv_en  (adv_q[n]),
            .gate_en (gate_q[n]),
            .bypass  (byp_q[n]),
            .high_cnt(high_flat[n*CW +: CW]),
            .low_cnt (low_flat[n*CW +: CW]),
            .pwm     (out_all[n])
        );
    end

    // Split channel outputs between pins and the internal net.
    assign pwm_ext = out_all[NEXT-1:0];
    assign pwm_int = out_all[NCH-1];

endmodule

// File: rtl/pwm_wh_chk.sv
// Module pwm_wh_chk
// Assertion checker for pwm_wh_ctrl, attached by bind. It watches the bus
// port, the register-file outputs and the channel outputs.
module pwm_wh_chk
    import pwm_wh_pkg::*;
#(
    parameter int NCH = 7,
    parameter int CW  = 16,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_wen,
    input logic [DW-1:0]     bus_wdata,
    input logic [NCH-1:0]    byp_q,
    input logic [NCH-1:0]    gate_q,
    input logic [NCH-1:0]    run_q,
    input logic [NCH-1:0]    adv_q,
    input logic [NCH*CW-1:0] high_flat,
    input logic [NCH-1:0]    out_all
);

    localparam int MAP_END = OFS_CH_BASE + NCH * CH_STRIDE;

    logic unmapped;
    assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr >= AW'(MAP_END));

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(run_q & adv_q & gate_q)) & out_all) == '0); // R5

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && unmapped) |=> ($stable(run_q) && $stable(adv_q) &&
            $stable(gate_q) && $stable(byp_q) && $stable(high_flat))); // R11

    AST_ADV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == AW'(OFS_ADV)) |=>
            (adv_q == $past(bus_wdata[NCH-1:0]))); // R10

    AST_HIGH0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == AW'(high_ofs(0))) |=>
            (high_flat[CW-1:0] == $past(bus_wdata[CW-1:0]))); // R10

    for (genvar n = 0; n < NCH; n++) begin : g_restart
        AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(run_q[n]) && adv_q[n] && gate_q[n] && !byp_q[n]) |->
                out_all[n]); // R6
    end

endmodule

bind pwm_wh_ctrl pwm_wh_chk #(
    .NCH(NCH), .CW(CW), .AW(AW), .DW(DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wen  (bus_wen),
    .bus_wdata(bus_wdata),
    .byp_q    (byp_q),
    .gate_q   (gate_q),
    .run_q    (run_q),
    .adv_q    (adv_q),
    .high_flat(high_flat),
    .out_all  (out_all)
);

// File: tb/sim_pwm_wh_ctrl.sv
// Bench for pwm_wh_ctrl: a register read-back table, then directed
// waveform tests sampled at falling edges.
module sim_pwm_wh_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_ext;
    logic        pwm_int;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwm_wh_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wen  (bus_wen),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_ext  (pwm_ext),
        .pwm_int  (pwm_int)
    );

    // Register read-back vectors: address, write data, expected read.
    localparam int NV = 11;
    localparam logic [7:0]  TV_A [NV] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
        8'h2C, 8'h40, 8'h44, 8'h48, 8'h06, 8'hFC};
    localparam logic [31:0] TV_W [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h1234_5678, 32'hABCD_1234, 32'h0000_FFFF,
        32'h0001_0005, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF};
    localparam logic [31:0] TV_E [NV] = '{32'h0FFF_FFFF, 32'h0000_3FFF,
        32'h0000_007F, 32'h0000_0078, 32'h0000_1234, 32'h0000_FFFF,
        32'h0000_0005, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
        32'h0000_0000};

    function automatic logic [6:0] outs();
        return {pwm_int, pwm_ext};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register; called at a falling edge, returns at the next.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Program and start one channel; returns at sample index 0.
    task automatic start_ch(input int ch, input logic [15:0] w,
                            input logic [15:0] h, input logic [31:0] sel,
                            input logic [31:0] gate_extra);
        wr(8'h08, 32'h0);
        wr(8'(16 + 8 * ch), {16'h0, w});
        wr(8'(20 + 8 * ch), {16'h0, h});
        wr(8'h00, sel);
        wr(8'h04, (32'h1 << ch) | gate_extra);
        wr(8'h0C, 32'h1 << ch);
        wr(8'h08, 32'h1 << ch);
    endtask

    // Compare n falling-edge samples with a W-high/H-low pattern.
    task automatic expect_wave(input string req, input int ch, input int w,
                               input int h, input int start, input int n);
        int bad = 0;
        int first = -1;
        logic got_first = 1'b0;
        logic exp_first = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic e;
            logic g;
            e = ((start + i) % (w + h)) < w;
            g = outs()[ch];
            if (g !== e) begin
                if (bad == 0) begin
                    first = i;
                    got_first = g;
                    exp_first = e;
                end
                bad++;
            end
            @(negedge clk);
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: ch%0d sample %0d actual=%b expected=%b (%0d bad)",
                     req, ch, first, got_first, exp_first, bad);
        end
    endtask

    task automatic expect_low(input string req, input int ch, input int n);
        expect_wave(req, ch, 0, 1, 0, n);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 outputs after reset", {25'h0, outs()}, 32'h0);
        rd(8'h00, v); check("R2 sel reg reset", v, 32'h0);
        rd(8'h44, v); check("R2 ch6 low count reset", v, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R11: register read-back table
        for (int k = 0; k < NV; k++) begin
            wr(TV_A[k], TV_W[k]);
            rd(TV_A[k], v);
            check($sformatf("R10/R11 readback addr %h", TV_A[k]), v, TV_E[k]);
        end
        rd(8'h04, v); check("R11 misaligned write left gate reg", v, 32'h3FFF);
        rd(8'h00, v); check("R11 unmapped write left sel reg", v, 32'h0FFF_FFFF);
        @(negedge clk);
        wr(8'h08, 0); wr(8'h0C, 0); wr(8'h04, 0); wr(8'h00, 0);

        // R3 / R1: basic waveform on external channel 0
        start_ch(0, 16'd3, 16'd2, 0, 0);
        expect_wave("R3 ch0 W3 H2", 0, 3, 2, 0, 20);
        // R5: gate cleared drives low
        wr(8'h04, 32'h0);
        expect_low("R5 gate clear", 0, 6);
        wr(8'h04, 32'h1);
        wr(8'h0C, 32'h0);
        expect_low("R5 advance clear", 0, 4);

        // R1: internal channel 6 only on pwm_int
        start_ch(6, 16'd1, 16'd1, 0, 0);
        check("R1 ext pins idle while ch6 runs", {26'h0, pwm_ext}, 32'h0);
        expect_wave("R1 ch6 W1 H1", 6, 1, 1, 0, 8);

        // R6: counter reset restarts the high phase
        start_ch(1, 16'd4, 16'd4, 0, 0);
        expect_wave("R6 ch1 before stop", 1, 4, 4, 0, 6);
        wr(8'h08, 32'h0);
        expect_low("R6 ch1 stopped", 1, 2);
        wr(8'h08, 32'h2);
        expect_wave("R6 ch1 restart", 1, 4, 4, 0, 10);

        // R7: advance clear freezes position
        start_ch(1, 16'd4, 16'd4, 0, 0);
        expect_wave("R7 ch1 before pause", 1, 4, 4, 0, 2);
        wr(8'h0C, 32'h0);
        expect_low("R7 ch1 paused", 1, 5);
        wr(8'h0C, 32'h2);
        expect_wave("R7 ch1 resumed", 1, 4, 4, 3, 10);

        // R9: count change takes effect at the period boundary
        start_ch(3, 16'd2, 16'd2, 0, 0);
        expect_wave("R9 ch3 old period", 3, 2, 2, 0, 1);
        wr(8'h28, 32'd5);
        expect_wave("R9 ch3 rest of old period", 3, 2, 2, 2, 2);
        expect_wave("R9 ch3 new period", 3, 5, 2, 0, 14);

        // R12: select fields and transition bit have no effect
        start_ch(5, 16'd2, 16'd3, 32'h001F_FFFF, 32'h1000);
        expect_wave("R12 ch5 with select/transition set", 5, 2, 3, 0, 15);

        // R8: bypass follows the source clock
        start_ch(4, 16'd7, 16'd7, 32'h0200_0000, 0);
        #0.5;
        check("R8 bypass low with clk low", {31'h0, outs()[4]}, 32'h0);
        @(posedge clk); #0.5;
        check("R8 bypass high with clk high", {31'h0, outs()[4]}, 32'h1);
        @(negedge clk);
        wr(8'h00, 32'h0);

        // R4: zero high count means 65536 cycles
        start_ch(2, 16'd0, 16'd1, 0, 0);
        expect_wave("R4 ch2 W=65536 H1", 2, 65536, 1, 0, 65540);

        // R2: reset while running
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 outputs low in reset", {25'h0, outs()}, 32'h0);
        rd(8'h08, v); check("R2 run reg cleared", v, 32'h0);
        rd(8'h20, v); check("R2 ch2 high count cleared", v, 32'h0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule